// File: doc/BRIEF.md
# Indexed Parameter Loader

This block takes one stream of parameter words for a small fully connected network. Each word carries an address, and the block steers the word to a single neuron. A weight goes to that neuron's weight FIFO. A bias goes into that neuron's bias register. The layer sizes are parameters, and the address fields take their widths from them.

The FIFOs sit outside the block, one for each neuron of every layer. They share one data bus. Each FIFO has its own valid and ready pair. Only the FIFO named by the decoded address sees the incoming valid, and the stream stalls while that FIFO is full. So one channel can fill every neuron.

Upstream sends each neuron's weights in input order. The block passes them on in that same order, so the accumulator can read them serially. A word whose address names a neuron or input that does not exist is thrown away and sets a sticky error flag. When the expected number of valid words has arrived, the block raises a done indication so that compute may start.

Top module: `param_steer`

## Requirements
- R1: The address packs three fields. The top ceil(log2 NL) bits are the layer. The next bit is the kind: 1 for bias, 0 for weight. The bottom RW bits are the parameter field, where RW is the largest value over all layers of ceil(log2 N) + ceil(log2 J). For a weight, the input number sits in the low ceil(log2 J) bits of the parameter field and the neuron number sits above it. For a bias, the parameter field holds only the neuron number. Neuron slots are counted globally, all of layer 0 first, so a slot is the neuron number plus the neuron counts of all lower layers. Here N is the neuron count of the addressed layer and J is its input count.
- R2: For a valid, in-range weight word before done, only the addressed slot's `fifo_wr_valid` bit is high, and `fifo_wr_data` equals `in_data` in that same cycle. At all other times every `fifo_wr_valid` bit is low.
- R3: For an in-range weight word before done, `in_ready` equals the addressed slot's `fifo_wr_ready`. For every other word, `in_ready` is high.
- R4: An in-range bias word before done is accepted whatever the FIFO readies are. The addressed slot's bias output shows the word after the accepting clock. All other bias slots keep their values.
- R5: A word whose layer, neuron or input number is beyond the implemented size is consumed without any write. `addr_err` is set from the next cycle and stays set until reset.
- R6: `load_done` rises in the cycle after the accepting edge of the TOTAL-th in-range word, where TOTAL is the sum over layers of N*J + N. It then stays high until reset.
- R7: Once `load_done` is high, every word is consumed and discarded. No FIFO write happens, no bias changes and the error flag does not change.
- R8: After reset, every bias slot reads 0, and `load_done`, `addr_err` and all FIFO valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parameter word present |
| in_ready | output | 1 | Parameter word consumed this cycle |
| in_addr | input | AW | Packed parameter address |
| in_data | input | DW | Parameter value |
| fifo_wr_valid | output | NT | Per-slot write valid, at most one bit high |
| fifo_wr_ready | input | NT | Per-slot FIFO not full |
| fifo_wr_data | output | DW | Shared write data |
| bias_q | output | NT*DW | Bias registers, slot k in bits k*DW +: DW |
| load_done | output | 1 | All expected parameters received |
| addr_err | output | 1 | Sticky out-of-range address flag |

## Verification
Completion detection can land in the same cycle as backpressure. The last word of the load is a weight whose FIFO reports full for two cycles, and an out-of-range word comes just before it. The bench checks each cycle that `load_done` stays low through the stall and through the discarded word. It also checks that `load_done` rises exactly one cycle after the stalled word is finally accepted. A second overlap comes from bias words sent while every FIFO ready is low; these must still be taken in one cycle.

// File: rtl/param_steer.sv
module param_steer #(
  parameter int DW = 8,
  parameter int NL = 2,
  parameter int LW [NL+1] = '{4, 3, 2},
  parameter int AW = 6,
  parameter int NT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_addr,
  input  logic [DW-1:0]    in_data,
  output logic [NT-1:0]    fifo_wr_valid,
  input  logic [NT-1:0]    fifo_wr_ready,
  output logic [DW-1:0]    fifo_wr_data,
  output logic [NT*DW-1:0] bias_q,
  output logic             load_done,
  output logic             addr_err
);
  function automatic int field_max();
    int m = 0;
    for (int l = 0; l < NL; l++)
      if ($clog2(LW[l+1]) + $clog2(LW[l]) > m) m = $clog2(LW[l+1]) + $clog2(LW[l]);
    return m;
  endfunction

  function automatic int slot_base(int upto);
    int s = 0;
    for (int l = 0; l < upto; l++) s += LW[l+1];
    return s;
  endfunction

  function automatic int word_total();
    int s = 0;
    for (int l = 0; l < NL; l++) s += LW[l+1] * LW[l] + LW[l+1];
    return s;
  endfunction

  localparam int LB    = $clog2(NL);
  localparam int RW    = field_max();
  localparam int TOTAL = word_total();
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int IW    = $clog2(NT);

  initial assert (AW == LB + 1 + RW && NT == slot_base(NL))
    else $error("param_steer: AW or NT does not match LW");

  logic [LB-1:0] lay;
  logic          is_bias;
  logic [RW-1:0] prm;
  logic [RW-1:0] nrn, inp;
  logic          hit;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] bias_r [NT];
  logic          wr_w;

  assign lay     = in_addr[AW-1 -: LB];
  assign is_bias = in_addr[RW];
  assign prm     = in_addr[RW-1:0];

  always_comb begin
    hit = 1'b0;
    idx = '0;
    nrn = '0;
    inp = '0;
    for (int l = 0; l < NL; l++) begin
      if (int'(lay) == l) begin
        nrn = is_bias ? prm : prm >> $clog2(LW[l]);
        inp = prm & RW'((1 << $clog2(LW[l])) - 1);
        if (int'(nrn) < LW[l+1] && (is_bias || int'(inp) < LW[l])) begin
          hit = 1'b1;
          idx = IW'(slot_base(l) + int'(nrn));
        end
      end
    end
  end

  assign wr_w          = !load_done && hit && !is_bias;
  assign in_ready      = !wr_w || fifo_wr_ready[idx];
  assign fifo_wr_valid = (in_valid && wr_w) ? (NT'(1) << idx) : '0;
  assign fifo_wr_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      load_done <= 1'b0;
      addr_err  <= 1'b0;
      for (int k = 0; k < NT; k++) bias_r[k] <= '0;
    end else if (in_valid && in_ready && !load_done) begin
      if (hit) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(TOTAL - 1)) load_done <= 1'b1;
        if (is_bias) bias_r[idx] <= in_data;
      end else begin
        addr_err <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_bias
    assign bias_q[g*DW +: DW] = bias_r[g];
  end

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_wr_valid));
  a_r3_stall_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> ($countones(fifo_wr_valid & ~fifo_wr_ready) == 1));
  a_r4_bias_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(bias_q));
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (fifo_wr_valid == '0 && in_ready));
endmodule

// File: tb/param_steer_test.sv
module param_steer_test;
  localparam int PERIOD = 10;
  localparam int NT = 5;
  localparam int AW = 6;
  localparam int TOTAL = 23;
  localparam int LWB [3] = '{4, 3, 2};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic [NT-1:0] fifo_wr_valid, fifo_wr_ready = '1;
  logic [7:0] fifo_wr_data;
  logic [NT*8-1:0] bias_q;
  logic load_done, addr_err;

  param_steer uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .fifo_wr_valid(fifo_wr_valid),
    .fifo_wr_ready(fifo_wr_ready), .fifo_wr_data(fifo_wr_data), .bias_q(bias_q),
    .load_done(load_done), .addr_err(addr_err));

  int checks = 0, failures = 0;
  int m_cnt = 0;
  bit m_done = 0, m_err = 0, accepted;
  logic [7:0] m_bias [NT];
  string phase = "";

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(bit c, string r, longint act, longint exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s%s actual=%0h expected=%0h at %0t", r, phase, act, exp, $time);
    end
  endtask

  // R1: layer in bit 5, kind in bit 4, parameter field in bits 3:0
  function automatic int mk(int l, int b, int n, int i);
    if (b) return (l << 5) | (1 << 4) | n;
    return (l << 5) | (n << $clog2(LWB[l])) | i;
  endfunction

  task automatic decode(logic [AW-1:0] a, output bit ok, output int idx, output bit isb);
    int l = a[5];
    int prm = a[3:0];
    int jw = $clog2(LWB[l]);
    int nr;
    isb = a[4];
    nr = isb ? prm : prm / (1 << jw);
    ok = (nr < LWB[l+1]) && (isb || (prm % (1 << jw)) < LWB[l]);
    idx = ok ? (l == 0 ? 0 : LWB[1]) + nr : 0;
  endtask

  task automatic tick();
    bit ok, isb, er;
    int idx;
    logic [NT-1:0] ev;
    #1;
    decode(in_addr, ok, idx, isb);
    er = !(!m_done && ok && !isb) || fifo_wr_ready[idx];
    ev = (in_valid && !m_done && ok && !isb) ? NT'(1) << idx : '0;
    chk(in_ready == er, "R3 in_ready", in_ready, er);
    chk(fifo_wr_valid == ev, "R2 fifo_wr_valid", fifo_wr_valid, ev);
    if (ev != 0) chk(fifo_wr_data == in_data, "R2 fifo_wr_data", fifo_wr_data, in_data);
    accepted = in_valid && er;
    @(posedge clk);
    if (accepted && !m_done) begin
      if (ok) begin
        m_cnt++;
        if (isb) m_bias[idx] = in_data;
        if (m_cnt == TOTAL) m_done = 1;
      end else m_err = 1;
    end
    @(negedge clk);
    chk(load_done == m_done, "R6 load_done", load_done, m_done);
    chk(addr_err == m_err, "R5 addr_err", addr_err, m_err);
    for (int k = 0; k < NT; k++)
      chk(bias_q[k*8 +: 8] == m_bias[k], "R4 bias", bias_q[k*8 +: 8], m_bias[k]);
  endtask

  task automatic send(int a, int d, int stall);
    in_valid = 1; in_addr = AW'(a); in_data = 8'(d);
    for (int t = 0; t < 50; t++) begin
      fifo_wr_ready = (t < stall) ? '0 : '1;
      tick();
      if (accepted) break;
    end
    in_valid = 0; fifo_wr_ready = '1;
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) m_bias[k] = '0;
    repeat (3) @(negedge clk);
    // R8: state straight out of reset
    chk(load_done == 0, "R8 load_done", load_done, 0);
    chk(addr_err == 0, "R8 addr_err", addr_err, 0);
    chk(bias_q == '0, "R8 bias_q", bias_q, 0);
    chk(fifo_wr_valid == '0, "R8 fifo_wr_valid", fifo_wr_valid, 0);
    rst_n = 1;
    tick();
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < 4; i++)
        send(mk(0, 0, n, i), 16 * n + i + 1, (n == 1 && i == 2) ? 3 : 0);
      if (n == 0) send(mk(0, 0, 3, 0), 8'hEE, 1);   // R5 neuron beyond layer 0
    end
    for (int n = 0; n < 3; n++) send(mk(0, 1, n, 0), 8'hA0 + n, 2);   // R4 under full FIFOs
    for (int n = 0; n < 2; n++)
      for (int i = 0; i < 3; i++)
        if (!(n == 1 && i == 2)) send(mk(1, 0, n, i), 8'h40 + 16 * n + i, n);
    send(mk(1, 0, 0, 3), 8'hE1, 0);   // R5 input beyond layer 1
    send(mk(1, 1, 2, 0), 8'hE2, 0);   // R5 bias neuron beyond layer 1
    for (int n = 0; n < 2; n++) send(mk(1, 1, n, 0), 8'hB0 + n, 0);
    send(mk(1, 0, 0, 3), 8'hE3, 0);
    send(mk(1, 0, 1, 2), 8'h5F, 2);   // R6 last word stalled by full FIFO
    phase = " [R7 after done]";
    send(mk(0, 0, 0, 0), 8'h11, 1);
    send(mk(0, 1, 1, 0), 8'h22, 0);
    send(mk(1, 1, 3, 0), 8'h33, 0);
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule